// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Master

This block is a serial master for a peripheral that has a single data line used in both directions. A host starts a transaction by giving an 8-bit command and a write byte. Bit 0 of the command chooses the direction. The block raises an active-high select, shifts the command out least significant bit first, and then either sends the write byte or turns the line around and collects one byte from the peripheral. When the transaction is over it gives a one-cycle completion pulse, and after a read it also presents the received byte.

The shared pin is modelled as three separate signals: a driven value, an output enable and a sensed value. The pad ring combines them into one bidirectional pin. The serial clock comes from the system clock. Each phase of the serial clock, high or low, lasts `HALF_CYC` system clocks. At a 50 MHz system clock, a value of 50 gives about 500 kHz and a value of 13 gives about 1.9 MHz.

The master changes its output only at the falling clock edge and holds it steady while the clock is high. It samples the peripheral in the last system clock of each low phase, at the edge that raises the serial clock. A transaction is always 16 serial clocks long.

Top module: `tw3_master`

## Requirements
- R1: After reset, sel, sclk, sdo_en, busy and done are 0 and rdata is 0.
- R2: A start accepted while idle raises busy, sel and sdo_en on the next clock. sclk stays low for exactly HALF_CYC clocks after sel rises, and only then goes high.
- R3: While sel is high, each high phase and each low phase of sclk lasts HALF_CYC clocks. There are exactly 16 rising edges per transaction. sclk is low whenever sel is low.
- R4: The command goes out first, bit 0 first, one bit per rising edge on rises 1 to 8. sdo does not change while sclk is high.
- R5: When cmd bit 0 is 0 (write), wdata goes out bit 0 first on rises 9 to 16. sdo_en stays 1 until sel drops.
- R6: When cmd bit 0 is 1 (read), sdo_en goes to 0 on the same clock as the falling edge that follows rise 8. It stays 0 for the rest of the transaction.
- R7: On a read, sdi is sampled in the last clock of the low phase before each of rises 9 to 16. The first sampled bit becomes rdata bit 0. rdata holds the byte from the cycle in which done is high.
- R8: One half-period after the final falling edge, sel and sdo_en drop. Exactly 2*HALF_CYC clocks after sel drops, done pulses and busy goes to 0 in the same cycle.
- R9: A start while busy is high is ignored. This includes the last busy cycle. Such a start does not change the transaction in progress and does not begin a new one.
- R10: done is high for exactly one cycle. A write transaction leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transaction request, accepted only while busy is 0 |
| cmd | input | 8 | Command byte; bit 0 = 1 requests a read |
| wdata | input | 8 | Byte to send on a write |
| busy | output | 1 | High from acceptance to completion |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte received by the last read |
| sel | output | 1 | Active-high peripheral select |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Value driven onto the shared data line |
| sdo_en | output | 1 | Output enable for the shared data line |
| sdi | input | 1 | Value sensed on the shared data line |

## Verification
Two events can coincide: a new start request and the completion of the current transaction. The bench provokes this in two ways. First, it raises start in exactly the last busy cycle; the start must be ignored, and sel and busy must stay low afterwards. Second, it raises start in the cycle where done is already visible; that start must be accepted, and the next transfer must follow the full timing. A scoreboard compares every bit taken from the line against the queued request. A peripheral model that drives the line only while sdo_en is low exposes any overlap between the two drivers at turnaround.

// File: rtl/tw3_pkg.sv
package tw3_pkg;
   // Decoded per-tick sequencer events
   typedef struct packed {
      logic rise;      // serial clock goes high
      logic fall;      // serial clock goes low
      logic rd_smp;    // capture the shared line (read byte)
      logic release_n; // stop driving after the command on a read
      logic sel_off;   // drop select and enable
      logic finish;    // transaction complete
   } tw3_evt_t;
endpackage

// File: rtl/tw3_halfdiv.sv
module tw3_halfdiv #(
   parameter int HALF_CYC = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int DW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
   localparam bit POW2 = ((HALF_CYC & (HALF_CYC - 1)) == 0);

   logic [DW-1:0] cnt_q;

   generate
      if (POW2) begin : g_wrap
         // Power-of-two: the counter wraps by itself
         assign tick = en && (&cnt_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (!en) cnt_q <= '0;
            else          cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_cmp
         assign tick = en && (cnt_q == DW'(HALF_CYC - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt_q <= '0;
            else if (!en)   cnt_q <= '0;
            else if (tick)  cnt_q <= '0;
            else            cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R3
endmodule

// File: rtl/tw3_evtdec.sv
module tw3_evtdec
   import tw3_pkg::*;
#(
   parameter int CMD_W = 8,
   parameter int DAT_W = 8,
   parameter int CW    = 6
) (
   input  logic          tick,
   input  logic          rd,
   input  logic [CW-1:0] cnt,
   output tw3_evt_t      evt
);
   localparam int TOT = CMD_W + DAT_W;

   logic [CW-1:0] nn;
   assign nn = cnt + 1'b1;   // index of the tick now ending

   always_comb begin
      evt.rise      = tick &&  nn[0] && (nn <= CW'(2*TOT - 1));
      evt.fall      = tick && !nn[0] && (nn <= CW'(2*TOT));
      evt.rd_smp    = evt.rise && rd && (nn >= CW'(2*CMD_W + 1));
      evt.release_n = tick && rd && (nn == CW'(2*CMD_W));
      evt.sel_off   = tick && (nn == CW'(2*TOT + 1));
      evt.finish    = tick && (nn == CW'(2*TOT + 3));
   end
endmodule

// File: rtl/tw3_txshift.sv
module tw3_txshift #(
   parameter int CMD_W = 8,
   parameter int DAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CMD_W-1:0] cmd,
   input  logic [DAT_W-1:0] wdata,
   input  logic             shift,
   output logic             bit_o
);
   localparam int TOT = CMD_W + DAT_W;
   logic [TOT-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q <= '0;
      else if (load)  sr_q <= {wdata, cmd};
      else if (shift) sr_q <= {1'b0, sr_q[TOT-1:1]};
   end
   assign bit_o = sr_q[0];
endmodule

// File: rtl/tw3_rxcap.sv
module tw3_rxcap #(
   parameter int DAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp,
   input  logic             din,
   output logic [DAT_W-1:0] cap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cap <= '0;
      else if (smp) cap <= {din, cap[DAT_W-1:1]}; // first bit ends in bit 0
   end
endmodule

// File: rtl/tw3_master.sv
module tw3_master
   import tw3_pkg::*;
#(
   parameter int CMD_W    = 8,
   parameter int DAT_W    = 8,
   parameter int HALF_CYC = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CMD_W-1:0] cmd,
   input  logic [DAT_W-1:0] wdata,
   output logic             busy,
   output logic             done,
   output logic [DAT_W-1:0] rdata,
   output logic             sel,
   output logic             sclk,
   output logic             sdo,
   output logic             sdo_en,
   input  logic             sdi
);
   localparam int TOT = CMD_W + DAT_W;
   localparam int CW  = $clog2(2*TOT + 4);

   generate
      if (HALF_CYC < 2) begin : g_bad_div
         $error("HALF_CYC must be at least 2");
      end
      if (CMD_W < 1 || DAT_W < 1) begin : g_bad_w
         $error("CMD_W and DAT_W must be positive");
      end
   endgenerate

   logic          busy_q, done_q, sel_q, sclk_q, oe_q, rd_q;
   logic [CW-1:0] n_q;
   logic [DAT_W-1:0] rdata_q, cap;
   logic          tick, accept;
   tw3_evt_t      evt;

   assign accept = start && !busy_q;

   tw3_halfdiv #(.HALF_CYC(HALF_CYC)) u_div (
      .clk(clk), .rst_n(rst_n), .en(busy_q), .tick(tick));

   tw3_evtdec #(.CMD_W(CMD_W), .DAT_W(DAT_W), .CW(CW)) u_dec (
      .tick(tick), .rd(rd_q), .cnt(n_q), .evt(evt));

   tw3_txshift #(.CMD_W(CMD_W), .DAT_W(DAT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(accept), .cmd(cmd), .wdata(wdata),
      .shift(evt.fall), .bit_o(sdo));

   tw3_rxcap #(.DAT_W(DAT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .smp(evt.rd_smp), .din(sdi), .cap(cap));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         sel_q   <= 1'b0;
         sclk_q  <= 1'b0;
         oe_q    <= 1'b0;
         rd_q    <= 1'b0;
         n_q     <= '0;
         rdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               sel_q  <= 1'b1;
               oe_q   <= 1'b1;
               rd_q   <= cmd[0];
               n_q    <= '0;
            end
         end else begin
            if (tick)          n_q    <= n_q + 1'b1;
            if (evt.rise)      sclk_q <= 1'b1;
            if (evt.fall)      sclk_q <= 1'b0;
            if (evt.release_n) oe_q   <= 1'b0;
            if (evt.sel_off) begin
               sel_q <= 1'b0;
               oe_q  <= 1'b0;
            end
            if (evt.finish) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               if (rd_q) rdata_q <= cap;
            end
         end
      end
   end

   assign busy   = busy_q;
   assign done   = done_q;
   assign rdata  = rdata_q;
   assign sel    = sel_q;
   assign sclk   = sclk_q;
   assign sdo_en = oe_q;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q |-> (!sclk_q && !oe_q)); // R3
   AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_q |-> $stable(sdo)); // R4
   AST_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_q) |-> $past(sel_q)); // R2
   AST_OE_DROP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_q) |-> !sclk_q); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R10
   AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(start)); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && !sel_q)); // R8
endmodule

// File: tb/tw3_master_tb.sv
`timescale 1ns/1ps
module tw3_master_tb_top;
   localparam int H = 5;

   typedef struct packed {
      logic [7:0] c;
      logic [7:0] w;
      logic [7:0] r;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [7:0] cmd = '0, wdata = '0;
   logic busy, done, sel, sclk, sdo, sdo_en, sdi;
   logic [7:0] rdata;

   logic p_drive = 1'b0, p_bit = 1'b0;
   assign sdi = sdo_en ? sdo : (p_drive ? p_bit : 1'b1);

   tw3_master #(.CMD_W(8), .DAT_W(8), .HALF_CYC(H)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .wdata(wdata),
      .busy(busy), .done(done), .rdata(rdata), .sel(sel), .sclk(sclk),
      .sdo(sdo), .sdo_en(sdo_en), .sdi(sdi));

   always #10 clk = ~clk;   // 50 MHz

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;
   item_t q[$];
   logic [7:0] exp_rdata = 8'h00;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Driver: push expected item, pulse start
   task automatic send(input logic [7:0] c, input logic [7:0] w, input logic [7:0] r);
      item_t it;
      while (busy) @(negedge clk);
      it.c = c; it.w = w; it.r = r;
      q.push_back(it);
      cmd = c; wdata = w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy || q.size() != 0);
   endtask

   // Monitor + peripheral model
   logic prev_sclk = 0, prev_sel = 0, prev_done = 0;
   bit   in_tx = 0, wdone = 0, first = 0;
   int   rises = 0, plen = 0, gap = 0, pidx = 0;
   logic [7:0] cbits, dbits;
   item_t cur;

   always @(negedge clk) begin
      if (rst_n) begin
         if (sdo_en && p_drive) check(0, "R6 contention", 1, 0);
         if (done && prev_done) check(0, "R10 done width", 2, 1);
         if (done && !wdone)    check(0, "R10 spurious done", 1, 0);
         if (sel && !prev_sel) begin
            in_tx = 1; rises = 0; plen = 1; first = 1;
            if (q.size() == 0) check(0, "R9 unexpected transaction", 1, 0);
            else cur = q[0];
         end else if (in_tx && sel) begin
            if (sclk != prev_sclk) begin
               if (first) check(plen == H, "R2 select-to-first-rise", plen, H);
               else if (plen != H) check(0, "R3 phase length", plen, H);
               first = 0; plen = 1;
               if (sclk) begin
                  rises++;
                  if (rises <= 8) cbits[rises-1] = sdo;
                  else if (!cur.c[0]) dbits[rises-9] = sdo;
               end else begin
                  if (rises == 8 && cur.c[0]) begin
                     check(sdo_en == 1'b0, "R6 release at 8th fall", sdo_en, 0);
                     p_drive = 1; p_bit = cur.r[0]; pidx = 1;
                  end else if (rises == 8) begin
                     check(sdo_en == 1'b1, "R5 write keeps drive", sdo_en, 1);
                  end else if (p_drive && rises < 16) begin
                     p_bit = cur.r[pidx]; pidx++;
                  end
                  if (rises == 16) p_drive = 0;
               end
            end else plen++;
         end
         if (!sel && prev_sel && in_tx) begin
            check(plen == H, "R8 last half-period before sel drop", plen, H);
            check(rises == 16, "R3 rise count", rises, 16);
            check(cbits == cur.c, "R4 command bits", cbits, cur.c);
            if (!cur.c[0]) check(dbits == cur.w, "R5 write bits", dbits, cur.w);
            check(sdo_en == 1'b0, "R8 enable off with sel", sdo_en, 0);
            gap = 0; wdone = 1;
         end else if (wdone) begin
            gap++;
            if (done) begin
               check(gap == 2*H, "R8 sel-drop to done", gap, 2*H);
               check(busy == 1'b0, "R8 busy low with done", busy, 0);
               if (cur.c[0]) begin
                  check(rdata == cur.r, "R7 read data", rdata, cur.r);
                  exp_rdata = cur.r;
               end else
                  check(rdata == exp_rdata, "R10 write keeps rdata", rdata, exp_rdata);
               void'(q.pop_front());
               wdone = 0; in_tx = 0;
            end
         end
      end
      prev_sclk = sclk; prev_sel = sel; prev_done = done;
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         check(0, "watchdog", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({sel, sclk, sdo_en, busy, done, rdata} == '0, "R1 reset state",
            {sel, sclk, sdo_en, busy, done, rdata}, 0);

      send(8'hA4, 8'h3C, 8'h00);  wait_idle();   // write
      send(8'h81, 8'h00, 8'hA5);  wait_idle();   // read
      send(8'hFF, 8'h77, 8'h01);  wait_idle();   // read, all-ones cmd
      send(8'h00, 8'hFF, 8'h00);  wait_idle();   // write all ones
      send(8'h53, 8'h00, 8'h80);  wait_idle();   // read MSB only

      // R9: start mid-transaction is ignored
      send(8'h12, 8'hC3, 8'h00);
      repeat (40) @(negedge clk);
      cmd = 8'hEF; wdata = 8'h11; start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_idle();
      begin
         bit quiet = 1;
         repeat (3*H) begin
            @(negedge clk);
            if (sel || busy) quiet = 0;
         end
         check(quiet, "R9 mid-transfer start ignored", !quiet, 0);
      end

      // R9: start in the final busy cycle is ignored
      send(8'h6D, 8'h00, 8'h5A);
      while (!sel) @(negedge clk);
      while (sel)  @(negedge clk);
      repeat (2*H - 1) @(negedge clk);
      cmd = 8'h99; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b1, "R8 done at end of guard", done, 1);
      begin
         bit quiet = 1;
         repeat (3*H) begin
            @(negedge clk);
            if (sel || busy) quiet = 0;
         end
         check(quiet, "R9 last-cycle start ignored", !quiet, 0);
      end

      // Start in the cycle done is visible is accepted (back-to-back)
      send(8'hC1, 8'h00, 8'h3E);
      send(8'h2A, 8'h96, 8'h00);
      wait_idle();

      repeat (5) @(negedge clk);
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule